// File: doc/BRIEF.md
# Interrupt Moderation Delay Timers

This block holds the two interrupt moderation timers that serve one direction (receive or transmit) of a network controller. Each completed packet restarts a retriggerable packet-gap timer, so that a steady stream of packets keeps the interrupt back. A second, absolute timer starts on the first packet of a burst and is never restarted, which bounds how long a busy stream can hold the interrupt off. When either timer runs out, the block sends a one-cycle post pulse for its cause (receive-timer or transmit-done) to the interrupt controller.

The interrupt controller is outside the block. It tells the block, through a one-cycle strobe, whenever it actually raises its interrupt line for any reason. Both timers are then cancelled, and the block returns a one-cycle cause-set pulse if either timer was running, so that the pending cause is recorded with that interrupt. A flush strobe from the register file, which clears its own bit, forces an immediate post. On the transmit side the completion is qualified by the delay-enable bit of the descriptor. On the receive side that input is tied high.

Delay values count in units of 1024 ns. The parameter `UNIT_CYCLES` gives the number of clock cycles in one unit.

Top module: `intr_delay_timers`

## Requirements
- R1: After reset, `cause_post` and `cause_set` are low and no timer is running, so with no stimulus neither output rises.
- R2: A qualified completion (`pkt_done` and `delay_en` high at a clock edge) with `pkt_delay` = P > 0 loads the packet timer. If nothing intervenes, `cause_post` is high for one cycle, starting exactly P*UNIT_CYCLES clock edges after that completion edge.
- R3: A qualified completion while the packet timer is running restarts it from the full current `pkt_delay`. The earlier deadline then produces no post.
- R4: A qualified completion with P > 0 and `abs_delay` = A > 0 starts the absolute timer only if that timer is idle. Later completions do not move its deadline, which comes A*UNIT_CYCLES edges after the start.
- R5: The absolute timer is not started by a completion that has P = 0 or A = 0.
- R6: A qualified completion with P = 0 raises `cause_post` in the cycle after that edge and arms no timer.
- R7: A completion with `delay_en` low is ignored: no post follows and no timer is armed.
- R8: An `irq_asserted` strobe stops both timers, which then never post for their old deadlines. `cause_set` is high in the next cycle exactly when at least one timer was running at that edge. A cancel takes priority over an expiry at the same edge.
- R9: A `flush` strobe raises `cause_post` in the next cycle.
- R10: `cause_post` is a registered OR of all post sources, so sources that coincide at one edge give a single one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_done | input | 1 | One-cycle strobe: a packet or descriptor completed |
| delay_en | input | 1 | Qualifies pkt_done (descriptor delay-enable bit; tie high for receive) |
| pkt_delay | input | DELAY_W | Packet-gap delay in 1024 ns units |
| abs_delay | input | DELAY_W | Absolute delay in 1024 ns units |
| flush | input | 1 | One-cycle strobe: force an immediate post |
| irq_asserted | input | 1 | One-cycle strobe: the interrupt line is being raised |
| cause_post | output | 1 | One-cycle request to post the timer cause |
| cause_set | output | 1 | One-cycle request to set the cause bit on a raised interrupt |

## Verification
Directed sequences come first, each aimed at one behaviour:
- an isolated packet, which shows the exact P-unit latency;
- completions spaced closer than P, which separate a retriggerable timer from a one-shot;
- a steady stream under a shorter absolute delay, which shows that the absolute deadline stays fixed while the packet timer keeps moving;
- zero delay values, which show the immediate post and the gating of the absolute timer.

Cancellation is tried with `irq_asserted`:
- while timers run;
- while they are idle;
- on the very edge of an expiry.

These cases separate cause-set from post and show that the cancel wins. Long random mixes of completions, enables, delay values, flushes and interrupt strobes follow, and every cycle is compared with a deadline-based model of both timers.

// File: rtl/idt_pkg.sv
package idt_pkg;

    // Control request for one countdown timer.
    typedef struct packed {
        logic arm;
        logic cancel;
    } tmr_ctl_t;

    // Every source that can request a post of the timer cause.
    typedef struct packed {
        logic pkt_expire;
        logic abs_expire;
        logic zero_delay;
        logic flush;
    } post_src_t;

    function automatic logic any_post(input post_src_t s);
        return s.pkt_expire | s.abs_expire | s.zero_delay | s.flush;
    endfunction

endpackage

// File: rtl/idt_countdown.sv
module idt_countdown
    import idt_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter bit RETRIGGER = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_ctl_t         ctl,
    input  logic [CNT_W-1:0] load_val,
    output logic             running,
    output logic             expire,
    output logic [CNT_W-1:0] count
);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    generate
        if (RETRIGGER) begin : g_retrig
            // Every arm request reloads the full value.
            assign accept = ctl.arm;
        end else begin : g_oneshot
            // Arm is taken only from idle (or when a cancel empties the timer).
            assign accept = ctl.arm && (!run_q || ctl.cancel);
        end
    endgenerate

    // A cancel at the same edge overrides the expiry.
    assign expire = run_q && (cnt_q == ONE) && !ctl.cancel;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (accept) begin
            run_q <= 1'b1;
            cnt_q <= load_val;
        end else if (ctl.cancel || expire) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (run_q) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign running = run_q;
    assign count   = cnt_q;

endmodule

// File: rtl/idt_post_merge.sv
module idt_post_merge
    import idt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  post_src_t src,
    input  logic      set_req,
    output logic      post_o,
    output logic      set_o
);

    logic post_q;
    logic set_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            post_q <= 1'b0;
            set_q  <= 1'b0;
        end else begin
            post_q <= any_post(src);
            set_q  <= set_req;
        end
    end

    assign post_o = post_q;
    assign set_o  = set_q;

endmodule

// File: rtl/intr_delay_timers.sv
module intr_delay_timers
    import idt_pkg::*;
#(
    parameter int DELAY_W     = 16,
    parameter int UNIT_CYCLES = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pkt_done,
    input  logic               delay_en,
    input  logic [DELAY_W-1:0] pkt_delay,
    input  logic [DELAY_W-1:0] abs_delay,
    input  logic               flush,
    input  logic               irq_asserted,
    output logic               cause_post,
    output logic               cause_set
);

    localparam int CNT_W = DELAY_W + $clog2(UNIT_CYCLES);
    localparam logic [CNT_W-1:0] UNIT_L = CNT_W'(UNIT_CYCLES);

    logic             done_q;
    logic             pkt_nz;
    logic             abs_nz;
    logic [CNT_W-1:0] pkt_load;
    logic [CNT_W-1:0] abs_load;
    logic             pkt_run, abs_run;
    logic             pkt_exp, abs_exp;
    logic [CNT_W-1:0] pkt_cnt, abs_cnt;
    tmr_ctl_t         pkt_ctl, abs_ctl;
    post_src_t        src;

    assign done_q   = pkt_done && delay_en;
    assign pkt_nz   = (pkt_delay != '0);
    assign abs_nz   = (abs_delay != '0);
    assign pkt_load = CNT_W'(pkt_delay) * UNIT_L;
    assign abs_load = CNT_W'(abs_delay) * UNIT_L;

    always_comb begin
        pkt_ctl.arm    = done_q && pkt_nz;
        pkt_ctl.cancel = irq_asserted;
        abs_ctl.arm    = done_q && pkt_nz && abs_nz;
        abs_ctl.cancel = irq_asserted;
    end

    idt_countdown #(.CNT_W(CNT_W), .RETRIGGER(1'b1)) u_pkt_tmr (
        .clk      (clk),
        .rst      (rst),
        .ctl      (pkt_ctl),
        .load_val (pkt_load),
        .running  (pkt_run),
        .expire   (pkt_exp),
        .count    (pkt_cnt)
    );

    idt_countdown #(.CNT_W(CNT_W), .RETRIGGER(1'b0)) u_abs_tmr (
        .clk      (clk),
        .rst      (rst),
        .ctl      (abs_ctl),
        .load_val (abs_load),
        .running  (abs_run),
        .expire   (abs_exp),
        .count    (abs_cnt)
    );

    always_comb begin
        src.pkt_expire = pkt_exp;
        src.abs_expire = abs_exp;
        src.zero_delay = done_q && !pkt_nz;
        src.flush      = flush;
    end

    idt_post_merge u_merge (
        .clk     (clk),
        .rst     (rst),
        .src     (src),
        .set_req (irq_asserted && (pkt_run || abs_run)),
        .post_o  (cause_post),
        .set_o   (cause_set)
    );

endmodule

// File: rtl/intr_delay_timers_chk.sv
module intr_delay_timers_chk #(
    parameter int DELAY_W = 16,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               pkt_done,
    input logic               delay_en,
    input logic [DELAY_W-1:0] pkt_delay,
    input logic [DELAY_W-1:0] abs_delay,
    input logic               flush,
    input logic               irq_asserted,
    input logic               cause_post,
    input logic               cause_set,
    input logic               pkt_run,
    input logic               abs_run,
    input logic [CNT_W-1:0]   abs_cnt
);

    localparam logic [CNT_W-1:0] C1 = CNT_W'(1);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !cause_post && !cause_set); // R1

    AST_PKT_ARMS: assert property (@(posedge clk) disable iff (rst)
        pkt_done && delay_en && (pkt_delay != '0) |=> pkt_run); // R3

    AST_ABS_FIXED: assert property (@(posedge clk) disable iff (rst)
        abs_run && (abs_cnt > C1) && !irq_asserted |=> abs_run && (abs_cnt == $past(abs_cnt) - C1)); // R4

    AST_ABS_GATED: assert property (@(posedge clk) disable iff (rst)
        !abs_run && pkt_done && ((pkt_delay == '0) || (abs_delay == '0)) |=> !abs_run); // R5

    AST_ZERO_POST: assert property (@(posedge clk) disable iff (rst)
        pkt_done && delay_en && (pkt_delay == '0) |=> cause_post); // R6

    AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        pkt_done && !delay_en && !pkt_run && !abs_run && !flush |=> !pkt_run && !abs_run && !cause_post); // R7

    AST_CANCEL_BOTH: assert property (@(posedge clk) disable iff (rst)
        irq_asserted && !(pkt_done && delay_en) |=> !pkt_run && !abs_run); // R8

    AST_SET_ON_IRQ: assert property (@(posedge clk) disable iff (rst)
        irq_asserted && (pkt_run || abs_run) |=> cause_set); // R8

    AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(irq_asserted && (pkt_run || abs_run)) |=> !cause_set); // R8

    AST_FLUSH_POST: assert property (@(posedge clk) disable iff (rst)
        flush |=> cause_post); // R9

endmodule

bind intr_delay_timers intr_delay_timers_chk #(.DELAY_W(DELAY_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pkt_done     (pkt_done),
    .delay_en     (delay_en),
    .pkt_delay    (pkt_delay),
    .abs_delay    (abs_delay),
    .flush        (flush),
    .irq_asserted (irq_asserted),
    .cause_post   (cause_post),
    .cause_set    (cause_set),
    .pkt_run      (pkt_run),
    .abs_run      (abs_run),
    .abs_cnt      (abs_cnt)
);

// File: tb/intr_delay_timers_test.sv
module intr_delay_timers_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 8;
    localparam int UNIT = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pkt_done = 1'b0;
    logic          delay_en = 1'b1;
    logic [DW-1:0] pkt_delay = '0;
    logic [DW-1:0] abs_delay = '0;
    logic          flush = 1'b0;
    logic          irq_asserted = 1'b0;
    logic          cause_post;
    logic          cause_set;

    int n_tests = 0;
    int n_fail  = 0;

    // Deadline model: a timer armed at edge e with L units is due at edge e + L*UNIT.
    int e = 0;
    int pk_dl = 0, ab_dl = 0;
    bit pk_f = 0, ab_f = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_delay_timers #(.DELAY_W(DW), .UNIT_CYCLES(UNIT)) uut (
        .clk          (clk),
        .rst          (rst),
        .pkt_done     (pkt_done),
        .delay_en     (delay_en),
        .pkt_delay    (pkt_delay),
        .abs_delay    (abs_delay),
        .flush        (flush),
        .irq_asserted (irq_asserted),
        .cause_post   (cause_post),
        .cause_set    (cause_set)
    );

    function automatic bit model_edge(output bit exp_set);
        bit pk_on, ab_on, fp, fa, zero;
        pk_on = pk_f && (pk_dl >= e);
        ab_on = ab_f && (ab_dl >= e);
        fp = pk_on && (pk_dl == e) && !irq_asserted;
        fa = ab_on && (ab_dl == e) && !irq_asserted;
        exp_set = irq_asserted && (pk_on || ab_on);
        if (irq_asserted) begin
            pk_on = 0;
            ab_on = 0;
        end
        zero = 0;
        if (pkt_done && delay_en) begin
            if (pkt_delay == 0) zero = 1;
            else begin
                pk_on = 1;
                pk_dl = e + int'(pkt_delay) * UNIT;
                if (abs_delay != 0 && !ab_on) begin
                    ab_on = 1;
                    ab_dl = e + int'(abs_delay) * UNIT;
                end
            end
        end
        pk_f = pk_on;
        ab_f = ab_on;
        e++;
        return fp | fa | zero | flush;
    endfunction

    task automatic cyc(input string req);
        bit ep, es;
        ep = model_edge(es);
        @(posedge clk);
        #1;
        n_tests++;
        if (cause_post !== ep || cause_set !== es) begin
            n_fail++;
            $display("FAIL %s at edge %0d: post=%b set=%b expected post=%b set=%b",
                     req, e - 1, cause_post, cause_set, ep, es);
        end
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) cyc(req);
    endtask

    task automatic done_pulse(input string req);
        pkt_done = 1'b1;
        cyc(req);
        pkt_done = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1: quiet after reset
        idle(6, "R1");

        // R2: isolated packet, P=2 -> post 8 edges later
        pkt_delay = 2;
        abs_delay = 0;
        done_pulse("R2");
        idle(12, "R2");

        // R3: retrigger before the deadline moves it out
        pkt_delay = 3;
        done_pulse("R3");
        idle(6, "R3");
        done_pulse("R3");
        idle(16, "R3");

        // R4: stream every 5 cycles; packet timer never expires, absolute one does
        pkt_delay = 3;
        abs_delay = 5;
        for (int k = 0; k < 7; k++) begin
            done_pulse("R4");
            idle(4, "R4");
        end
        idle(30, "R4");

        // R5: P=0 with A set, then P set with A=0
        pkt_delay = 0;
        abs_delay = 5;
        done_pulse("R5");
        idle(25, "R5");
        pkt_delay = 2;
        abs_delay = 0;
        done_pulse("R5");
        idle(12, "R5");

        // R6: zero delay posts at once
        pkt_delay = 0;
        done_pulse("R6");
        idle(3, "R6");

        // R7: completion with delay enable low is ignored
        pkt_delay = 2;
        delay_en = 1'b0;
        done_pulse("R7");
        idle(12, "R7");
        delay_en = 1'b1;

        // R8: cancel while both timers run, then while idle
        pkt_delay = 4;
        abs_delay = 6;
        done_pulse("R8");
        idle(5, "R8");
        irq_asserted = 1'b1;
        cyc("R8");
        irq_asserted = 1'b0;
        idle(30, "R8");
        irq_asserted = 1'b1;
        cyc("R8");
        irq_asserted = 1'b0;
        idle(2, "R8");
        // R8: cancel on the exact expiry edge wins
        pkt_delay = 1;
        abs_delay = 0;
        done_pulse("R8");
        idle(UNIT - 1, "R8");
        irq_asserted = 1'b1;
        cyc("R8");
        irq_asserted = 1'b0;
        idle(4, "R8");

        // R9: flush
        flush = 1'b1;
        cyc("R9");
        flush = 1'b0;
        idle(2, "R9");

        // R10: flush and zero-delay completion coincide -> one pulse
        pkt_delay = 0;
        flush = 1'b1;
        pkt_done = 1'b1;
        cyc("R10");
        flush = 1'b0;
        pkt_done = 1'b0;
        idle(3, "R10");

        // Random mix against the deadline model
        void'($urandom(32'h1d7a_55c3));
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 19) == 0) pkt_delay = DW'($urandom_range(0, 4));
            if ($urandom_range(0, 19) == 0) abs_delay = DW'($urandom_range(0, 9));
            pkt_done     = ($urandom_range(0, 6) == 0);
            delay_en     = ($urandom_range(0, 4) != 0);
            flush        = ($urandom_range(0, 40) == 0);
            irq_asserted = ($urandom_range(0, 25) == 0);
            cyc("R2");
        end
        pkt_done = 1'b0;
        flush = 1'b0;
        irq_asserted = 1'b0;
        idle(50, "R2");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule